// File: doc/BRIEF.md
# Prioritised Maskable Interrupt Controller

This block gathers interrupt requests from one non-maskable input, a bank of external request pins and a set of internal peripheral request lines, and hands a single winning request to a processor core. Each external pin passes through a two-stage synchronizer. It has an individual enable, a sense selection and a sticky status flag that software clears. Each maskable source carries a 3-bit programmable priority.

Two arbitration schemes are available through a 2-bit mode input. In the global scheme a single mask bit blocks every maskable source and the programmed priorities play no part. In the eight-level scheme a source is accepted only when its priority is above the core's current 3-bit mask level, or when its priority is 7. The non-maskable request always wins. The winning vector number and level are registered. They are held steady until the core acknowledges.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `irq_req` is 0 and every bit of `ext_flag` is 0.
- R2: A non-maskable event is the selected edge of `nmi_pin` (rising when `nmi_rise_sel`=1, falling when 0). It makes a pending request that beats every maskable source in every mode and at every mask level. The request is presented as vector 0 with level 7. Acknowledging it clears the pending state.
- R3: Each external pin's sense is chosen by {`sense_rise`,`sense_fall`}: 00 low level, 01 falling edge, 10 rising edge, 11 both edges. A pin change driven before clock edge k shows in `ext_flag` after edge k+2. It shows on `irq_req` after edge k+3.
- R4: In the edge senses the flag stays set until a `flag_clr` pulse, and a new edge in the same cycle wins over the clear. In low-level sense the flag follows the synchronized pin and `flag_clr` has no effect.
- R5: An external pin requests only while its flag and its registered enable are both 1. The flag is set whatever the enable is, and a change of `ext_en` reaches arbitration one cycle late.
- R6: When `ctrl_mode`=2, a maskable source is accepted only if its priority is 7 or greater than `cpu_mask`.
- R7: In mode 2 the accepted source with the highest priority wins, and ties go to the lowest vector. Vectors: 0 non-maskable, 1+i external pin i, 1+NUM_EXT+j internal line j. The priority of vector v sits in `src_prio[(v-1)*3 +: 3]`.
- R8: For `ctrl_mode` 0 and for the reserved codes 1 and 3, `global_mask`=1 blocks all maskable sources. With it at 0 the lowest pending vector wins, priorities are ignored and the reported level is 0.
- R9: A winner reaches `irq_req`/`irq_vec`/`irq_lvl` one cycle after it is present. While `irq_req` is 1 and `ack` is 0, all three stay unchanged, even if the source is withdrawn or disabled.
- R10: `ack` while `irq_req` is 1 drops `irq_req` on the next cycle, and arbitration resumes on the cycle after that. `ack` while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable request pin (asynchronous) |
| nmi_rise_sel | input | 1 | 1 selects rising edge, 0 falling edge for the non-maskable pin |
| ext_pin | input | NUM_EXT | External request pins (asynchronous) |
| ext_en | input | NUM_EXT | Per-pin request enable |
| sense_rise | input | NUM_EXT | Per-pin rise sense bit |
| sense_fall | input | NUM_EXT | Per-pin fall sense bit |
| flag_clr | input | NUM_EXT | Per-pin flag clear pulse |
| int_req | input | NUM_INT | Internal peripheral request lines (synchronous) |
| src_prio | input | (NUM_EXT+NUM_INT)*3 | Priority of each maskable source |
| cpu_mask | input | 3 | Core's current mask level |
| ctrl_mode | input | 2 | Arbitration mode: 2 eight-level, others global mask |
| global_mask | input | 1 | Global mask bit used outside mode 2 |
| ack | input | 1 | Core acknowledge of the presented request |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 6 | Vector number of the presented request |
| irq_lvl | output | 3 | Level of the presented request |
| ext_flag | output | NUM_EXT | Per-pin status flags |

## Verification
The bench builds the block with its default size: twelve external pins and four internal lines, which gives seventeen vectors. The pin bank is large enough to run all four sense codes side by side on different pins. The internal lines sit at the top of the vector range, so the bench can show a high vector beating a low one on level in mode 2, and a low vector winning over a higher priority in the global mode. A behavioural model in the bench tracks flags, enables, the pending non-maskable event and the output register on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    localparam int VEC_W = 6;
    localparam int KEY_W = LVL_W + 1;

    localparam logic [1:0]       MODE_LEVELS = 2'd2;
    localparam logic [LVL_W-1:0] LVL_TOP     = '1;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    function automatic logic accepts(input logic             levels_mode,
                                     input logic             gmask,
                                     input logic [LVL_W-1:0] prio,
                                     input logic [LVL_W-1:0] mask);
        if (levels_mode)
            return (prio == LVL_TOP) || (prio > mask);
        return !gmask;
    endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic cur,
    output logic prev
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= IDLE;
            cur  <= IDLE;
            prev <= IDLE;
        end else begin
            meta <= pin;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic en,
    input  logic sense_rise,
    input  logic sense_fall,
    input  logic clr,
    output logic flag,
    output logic req
);
    logic   cur, prev, rise, fall, flag_d, en_q;
    sense_e sel;

    irq_sync_edge #(.IDLE(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (pin),
        .cur (cur),
        .prev(prev)
    );

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;
    assign sel  = sense_e'({sense_rise, sense_fall});

    always_comb begin
        unique case (sel)
            SENSE_LOW:  flag_d = ~cur;
            SENSE_FALL: flag_d = fall | (flag & ~clr);
            SENSE_RISE: flag_d = rise | (flag & ~clr);
            SENSE_BOTH: flag_d = rise | fall | (flag & ~clr);
            default:    flag_d = flag;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            en_q <= 1'b0;
        end else begin
            flag <= flag_d;
            en_q <= en;
        end
    end

    assign req = flag & en_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 17
) (
    input  logic [NUM_SRC-1:0]           pend,
    input  logic [(NUM_SRC-1)*LVL_W-1:0] prio,
    input  logic                         levels_mode,
    input  logic                         gmask,
    input  logic [LVL_W-1:0]             mask,
    output grant_t                       grant
);
    localparam logic [KEY_W-1:0] NMI_KEY = {1'b1, {LVL_W{1'b0}}};

    logic [KEY_W-1:0] best_key;
    logic [LVL_W-1:0] p, eff;

    always_comb begin
        grant    = '0;
        best_key = '0;
        p        = '0;
        eff      = '0;
        if (pend[0]) begin
            grant.valid = 1'b1;
            grant.vec   = '0;
            grant.lvl   = LVL_TOP;
            best_key    = NMI_KEY;
        end
        for (int s = 1; s < NUM_SRC; s++) begin
            p   = prio[(s-1)*LVL_W +: LVL_W];
            eff = levels_mode ? p : '0;
            if (pend[s] && accepts(levels_mode, gmask, p, mask) &&
                (!grant.valid || {1'b0, eff} > best_key)) begin
                grant.valid = 1'b1;
                grant.vec   = VEC_W'(s);
                grant.lvl   = eff;
                best_key    = {1'b0, eff};
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_EXT = 12,
    parameter int NUM_INT = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               nmi_pin,
    input  logic                               nmi_rise_sel,
    input  logic [NUM_EXT-1:0]                 ext_pin,
    input  logic [NUM_EXT-1:0]                 ext_en,
    input  logic [NUM_EXT-1:0]                 sense_rise,
    input  logic [NUM_EXT-1:0]                 sense_fall,
    input  logic [NUM_EXT-1:0]                 flag_clr,
    input  logic [NUM_INT-1:0]                 int_req,
    input  logic [(NUM_EXT+NUM_INT)*LVL_W-1:0] src_prio,
    input  logic [LVL_W-1:0]                   cpu_mask,
    input  logic [1:0]                         ctrl_mode,
    input  logic                               global_mask,
    input  logic                               ack,
    output logic                               irq_req,
    output logic [VEC_W-1:0]                   irq_vec,
    output logic [LVL_W-1:0]                   irq_lvl,
    output logic [NUM_EXT-1:0]                 ext_flag
);
    localparam int NUM_SRC = 1 + NUM_EXT + NUM_INT;

    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_SRC-1:0] pend;
    logic               nmi_cur, nmi_prev, nmi_hit, nmi_taken, nmi_pend;
    grant_t             grant;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        irq_ext_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .pin       (ext_pin[i]),
            .en        (ext_en[i]),
            .sense_rise(sense_rise[i]),
            .sense_fall(sense_fall[i]),
            .clr       (flag_clr[i]),
            .flag      (ext_flag[i]),
            .req       (ext_req[i])
        );
    end

    irq_sync_edge #(.IDLE(1'b0)) u_nmi_sync (
        .clk (clk),
        .rst (rst),
        .pin (nmi_pin),
        .cur (nmi_cur),
        .prev(nmi_prev)
    );

    assign nmi_hit   = nmi_rise_sel ? (nmi_cur & ~nmi_prev) : (~nmi_cur & nmi_prev);
    assign nmi_taken = irq_req & ack & (irq_vec == '0);

    always_ff @(posedge clk) begin
        if (rst) nmi_pend <= 1'b0;
        else     nmi_pend <= nmi_hit | (nmi_pend & ~nmi_taken);
    end

    assign pend = {int_req, ext_req, nmi_pend};

    irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend       (pend),
        .prio       (src_prio),
        .levels_mode(ctrl_mode == MODE_LEVELS),
        .gmask      (global_mask),
        .mask       (cpu_mask),
        .grant      (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            irq_lvl <= '0;
        end else if (irq_req) begin
            if (ack) irq_req <= 1'b0;
        end else if (grant.valid) begin
            irq_req <= 1'b1;
            irq_vec <= grant.vec;
            irq_lvl <= grant.lvl;
        end
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ctrl_mode,
    input logic [LVL_W-1:0] cpu_mask,
    input logic             global_mask,
    input logic             ack,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic [LVL_W-1:0] irq_lvl
);
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        irq_req && !ack |=> irq_req && $stable(irq_vec) && $stable(irq_lvl));

    assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
        irq_req && ack |=> !irq_req);

    assert_nmi_top_level_R2: assert property (@(posedge clk) disable iff (rst)
        irq_req && irq_vec == '0 |-> irq_lvl == LVL_TOP);

    assert_level_accept_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) && $past(ctrl_mode) == MODE_LEVELS && irq_vec != '0
        |-> (irq_lvl == LVL_TOP || irq_lvl > $past(cpu_mask)));

    assert_global_mask_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) && $past(ctrl_mode) != MODE_LEVELS && irq_vec != '0
        |-> !$past(global_mask) && irq_lvl == '0);

    assert_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> int'(irq_vec) < NUM_SRC);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_mode  (ctrl_mode),
    .cpu_mask   (cpu_mask),
    .global_mask(global_mask),
    .ack        (ack),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_lvl    (irq_lvl)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 12;
    localparam int NI = 4;
    localparam int NS = 1 + NE + NI;

    logic              clk = 1'b0;
    logic              rst;
    logic              nmi_pin, nmi_rise_sel;
    logic [NE-1:0]     ext_pin, ext_en, sense_rise, sense_fall, flag_clr;
    logic [NI-1:0]     int_req;
    logic [(NE+NI)*3-1:0] src_prio;
    logic [2:0]        cpu_mask;
    logic [1:0]        ctrl_mode;
    logic              global_mask, ack;
    logic              irq_req;
    logic [5:0]        irq_vec;
    logic [2:0]        irq_lvl;
    logic [NE-1:0]     ext_flag;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_EXT(NE), .NUM_INT(NI)) u_dut (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .nmi_rise_sel(nmi_rise_sel),
        .ext_pin(ext_pin), .ext_en(ext_en), .sense_rise(sense_rise),
        .sense_fall(sense_fall), .flag_clr(flag_clr), .int_req(int_req),
        .src_prio(src_prio), .cpu_mask(cpu_mask), .ctrl_mode(ctrl_mode),
        .global_mask(global_mask), .ack(ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .ext_flag(ext_flag)
    );

    // ---------------- behavioural reference model ----------------
    int m_p1[NE], m_p2[NE], m_p3[NE], m_flag[NE], m_en[NE];
    int m_n1, m_n2, m_n3, m_npend, m_req, m_vec, m_lvl;

    always @(posedge clk) begin
        int best, rank, pr, act, ok, taken, edge_seen, nf;
        if (rst) begin
            for (int i = 0; i < NE; i++) begin
                m_p1[i] = 1; m_p2[i] = 1; m_p3[i] = 1; m_flag[i] = 0; m_en[i] = 0;
            end
            m_n1 = 0; m_n2 = 0; m_n3 = 0; m_npend = 0;
            m_req = 0; m_vec = 0; m_lvl = 0;
        end else begin
            best = -1; rank = -1;
            if (m_npend != 0) begin best = 0; rank = 8; end
            for (int v = 1; v < NS; v++) begin
                if (v <= NE) act = (m_flag[v-1] != 0 && m_en[v-1] != 0) ? 1 : 0;
                else         act = int_req[v-1-NE];
                pr = src_prio[(v-1)*3 +: 3];
                if (ctrl_mode == 2'd2) ok = (pr == 7 || pr > cpu_mask) ? 1 : 0;
                else begin ok = global_mask ? 0 : 1; pr = 0; end
                if (act != 0 && ok != 0 && pr > rank) begin best = v; rank = pr; end
            end
            taken = (m_req != 0 && ack && m_vec == 0) ? 1 : 0;
            if (m_req != 0) begin
                if (ack) m_req = 0;
            end else if (best >= 0) begin
                m_req = 1; m_vec = best; m_lvl = (best == 0) ? 7 : rank;
            end
            edge_seen = nmi_rise_sel ? (m_n2 == 1 && m_n3 == 0) : (m_n2 == 0 && m_n3 == 1);
            m_npend = (edge_seen != 0 || (m_npend != 0 && taken == 0)) ? 1 : 0;
            m_n3 = m_n2; m_n2 = m_n1; m_n1 = nmi_pin;
            for (int i = 0; i < NE; i++) begin
                if (!sense_rise[i] && !sense_fall[i]) nf = (m_p2[i] == 0) ? 1 : 0;
                else begin
                    nf = (m_flag[i] != 0 && !flag_clr[i]) ? 1 : 0;
                    if (sense_rise[i] && m_p2[i] == 1 && m_p3[i] == 0) nf = 1;
                    if (sense_fall[i] && m_p2[i] == 0 && m_p3[i] == 1) nf = 1;
                end
                m_flag[i] = nf;
                m_p3[i] = m_p2[i]; m_p2[i] = m_p1[i]; m_p1[i] = ext_pin[i];
                m_en[i] = ext_en[i];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (int'(irq_req) != m_req) begin
                errors++;
                $display("FAIL R9 model: irq_req=%0d expected %0d at %0t", irq_req, m_req, $time);
            end
            if (m_req != 0) begin
                checks++;
                if (int'(irq_vec) != m_vec || int'(irq_lvl) != m_lvl) begin
                    errors++;
                    $display("FAIL R7 model: vec/lvl=%0d/%0d expected %0d/%0d at %0t",
                             irq_vec, irq_lvl, m_vec, m_lvl, $time);
                end
            end
            for (int i = 0; i < NE; i++) begin
                checks++;
                if (int'(ext_flag[i]) != m_flag[i]) begin
                    errors++;
                    $display("FAIL R4 model: flag[%0d]=%0d expected %0d at %0t",
                             i, ext_flag[i], m_flag[i], $time);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_prio(input int idx, input int v);
        src_prio[idx*3 +: 3] = 3'(v);
    endtask

    task automatic ack_pulse();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic drain();
        int_req  = '0;
        flag_clr = '1;
        cyc(1);
        flag_clr = '0;
        for (int i = 0; i < 8; i++) begin
            ack = irq_req;
            cyc(1);
        end
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; nmi_pin = 1'b0; nmi_rise_sel = 1'b1;
        ext_pin = '1; ext_en = '0; sense_rise = '0; sense_fall = '1; flag_clr = '0;
        int_req = '0; cpu_mask = 3'd0; ctrl_mode = 2'd2; global_mask = 1'b0; ack = 1'b0;
        for (int i = 0; i < NE + NI; i++) set_prio(i, 1);
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 req after reset", irq_req, 0);
        check("R1 flags after reset", int'(ext_flag), 0);

        // R3 latency, falling edge on pin 3
        ext_en[3] = 1'b1;
        cyc(1);
        ext_pin[3] = 1'b0;
        cyc(3);
        check("R3 flag after third edge", ext_flag[3], 1);
        check("R9 req not yet", irq_req, 0);
        cyc(1);
        check("R9 req one cycle later", irq_req, 1);
        check("R7 vec pin3", irq_vec, 4);
        check("R7 lvl pin3", irq_lvl, 1);

        // R9 hold, R10 ack, R4 sticky and clear
        ext_pin[3] = 1'b1;
        cyc(4);
        check("R9 held", irq_req, 1);
        check("R9 vec held", irq_vec, 4);
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
        check("R10 req dropped", irq_req, 0);
        cyc(1);
        check("R4 sticky flag re-requests", irq_req, 1);
        flag_clr[3] = 1'b1;
        cyc(1);
        flag_clr[3] = 1'b0;
        check("R4 flag cleared", ext_flag[3], 0);
        ack_pulse();
        cyc(3);
        check("R10 nothing after clear", irq_req, 0);
        ack_pulse();
        check("R10 ack without request", irq_req, 0);

        // R7 higher level beats lower vector
        set_prio(NE, 3); set_prio(NE + 1, 6);
        int_req = 4'b0011;
        cyc(1);
        check("R7 higher level wins vec", irq_vec, 14);
        check("R7 higher level wins lvl", irq_lvl, 6);
        // R7 tie goes to lower vector
        set_prio(NE, 6);
        ack_pulse();
        cyc(1);
        check("R7 tie lower vector", irq_vec, 13);
        drain();

        // R6 mask comparison
        cpu_mask = 3'd5; set_prio(NE, 5); int_req = 4'b0001;
        cyc(3);
        check("R6 equal to mask refused", irq_req, 0);
        set_prio(NE, 6);
        cyc(1);
        check("R6 above mask accepted", irq_req, 1);
        check("R6 level 6", irq_lvl, 6);
        cpu_mask = 3'd7;
        ack_pulse();
        cyc(2);
        check("R6 mask 7 blocks 6", irq_req, 0);
        set_prio(NE, 7);
        cyc(1);
        check("R6 level 7 always accepted", irq_req, 1);
        check("R6 level 7 value", irq_lvl, 7);
        drain();

        // R2 non-maskable, rising edge
        nmi_pin = 1'b1;
        cyc(3);
        int_req = 4'b0001;
        cyc(1);
        check("R2 nmi wins", irq_req, 1);
        check("R2 nmi vector", irq_vec, 0);
        check("R2 nmi level", irq_lvl, 7);
        ack_pulse();
        cyc(1);
        check("R2 pending cleared, next source", irq_vec, 13);
        drain();
        // R2 falling edge in global mode with mask set
        ctrl_mode = 2'd0; global_mask = 1'b1; nmi_rise_sel = 1'b0;
        nmi_pin = 1'b0;
        cyc(4);
        check("R2 falling nmi accepted", irq_req, 1);
        check("R2 falling nmi vector", irq_vec, 0);
        ack_pulse();
        cyc(2);
        check("R2 no repeat after ack", irq_req, 0);
        global_mask = 1'b0; cpu_mask = 3'd0;

        // R8 global mode
        set_prio(0, 1); set_prio(NE + 1, 7);
        ext_en[0] = 1'b1;
        cyc(1);
        ext_pin[0] = 1'b0;
        cyc(3);
        int_req = 4'b0010;
        cyc(1);
        check("R8 lowest vector wins", irq_vec, 1);
        check("R8 level reported 0", irq_lvl, 0);
        flag_clr[0] = 1'b1; ack = 1'b1;
        cyc(1);
        flag_clr[0] = 1'b0; ack = 1'b0;
        cyc(1);
        check("R8 next source", irq_vec, 14);
        check("R8 next level 0", irq_lvl, 0);
        global_mask = 1'b1;
        ack_pulse();
        cyc(3);
        check("R8 global mask blocks", irq_req, 0);
        ctrl_mode = 2'd3; global_mask = 1'b0;
        cyc(1);
        check("R8 reserved mode acts global", irq_req, 1);
        check("R8 reserved mode vec", irq_vec, 14);
        ext_pin[0] = 1'b1; ext_en[0] = 1'b0;
        drain();
        ctrl_mode = 2'd2;

        // R4 low-level sense on pin 5
        sense_fall[5] = 1'b0; sense_rise[5] = 1'b0; ext_en[5] = 1'b1; set_prio(5, 4);
        cyc(1);
        ext_pin[5] = 1'b0;
        cyc(3);
        check("R3 level flag set", ext_flag[5], 1);
        cyc(1);
        check("R7 level pin vec", irq_vec, 6);
        check("R7 level pin lvl", irq_lvl, 4);
        flag_clr[5] = 1'b1;
        cyc(1);
        flag_clr[5] = 1'b0;
        check("R4 clear ignored in level sense", ext_flag[5], 1);
        ext_pin[5] = 1'b1;
        cyc(3);
        check("R4 level flag follows pin", ext_flag[5], 0);
        ack_pulse();
        cyc(2);
        check("R4 level request gone", irq_req, 0);

        // R3 both edges, R5 disabled pin still flags
        sense_rise[7] = 1'b1; sense_fall[7] = 1'b1;
        ext_pin[7] = 1'b0;
        cyc(3);
        check("R3 both: falling caught", ext_flag[7], 1);
        check("R5 disabled no request", irq_req, 0);
        flag_clr[7] = 1'b1;
        cyc(1);
        flag_clr[7] = 1'b0;
        ext_pin[7] = 1'b1;
        cyc(3);
        check("R3 both: rising caught", ext_flag[7], 1);
        ext_en[7] = 1'b1;
        cyc(1);
        check("R5 enable registered", irq_req, 0);
        cyc(1);
        check("R5 enabled request", irq_req, 1);
        check("R5 enabled vec", irq_vec, 8);
        // R9 in-flight request survives enable clear
        ext_en[7] = 1'b0;
        cyc(2);
        check("R9 in-flight kept", irq_req, 1);
        check("R9 in-flight vec", irq_vec, 8);
        ack_pulse();
        cyc(2);
        check("R5 disabled after ack", irq_req, 0);

        // R3 rising-only ignores falling
        sense_rise[8] = 1'b1; sense_fall[8] = 1'b0;
        ext_pin[8] = 1'b0;
        cyc(3);
        check("R3 rise-only ignores fall", ext_flag[8], 0);
        ext_pin[8] = 1'b1;
        cyc(3);
        check("R3 rise-only catches rise", ext_flag[8], 1);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule